// File: doc/BRIEF.md
# Variable-Page Fully Associative Address Translation Buffer

This block translates a 32-bit virtual address to a physical address by comparing it against every entry of a 64-entry table in the same cycle. Each entry describes one page, and each page can be 1 KB, 4 KB, 64 KB or 1 MB in size. The page size of an entry sets how many address bits take part in its compare. Each entry also holds an address-space identifier, which is checked against the current one, except for shared pages and in supervisor single-virtual mode. The block reports a hit, a miss or a multi-hit. On a hit it also returns the physical address and the protection and dirty fields of the matching entry, for a permission checker placed after it.

Software loads entries through a write port that replaces one whole entry at a time. A flush input drops every entry at once. A 6-bit replacement counter advances on each lookup that is not marked internal. It returns to zero when it reaches a programmable boundary, and its value is available to the refill software. Lookups are registered: the result arrives one cycle after the request strobe.

Top module: `vp_tlb`

## Requirements
- R1: After a synchronous reset every entry is cleared and invalid, `rsp_valid` is low and `repl_count` is 0.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `lk_req` high, and that result reflects the table contents before any write or flush issued in the same cycle as the request.
- R3: A write with `wr_en` high replaces every field of entry `wr_idx`, and the new contents apply from the next cycle on.
- R4: An entry whose valid bit is 0 never matches. `flush` clears the valid bit of all entries. A write in the same cycle as a flush is kept, with its own valid bit.
- R5: Size code 0, 1, 2 and 3 select page sizes of 1 KB, 4 KB, 64 KB and 1 MB. Only the virtual-address bits above the page size are compared with the stored page number, and stored page-number bits below the page size are ignored.
- R6: The entry's ASID must equal `cur_asid`, unless the entry is shared, or unless `sup_mode` and `single_virt` are both high.
- R7: `rsp_status` is 2'b01 when exactly one entry matches, 2'b00 when none match, and 2'b10 when two or more match. When the status is not a hit, `rsp_pa`, `rsp_prot` and `rsp_dirty` are zero.
- R8: On a hit, `rsp_pa` takes the bits at and above the page size from the stored physical page number, and the bits below the page size from the virtual address.
- R9: On a hit, `rsp_prot` and `rsp_dirty` carry the protection and dirty fields of the matching entry.
- R10: On a lookup with `lk_internal` low, `repl_count` becomes count+1 (modulo 64), or 0 if that value equals `repl_bound`. Lookups with `lk_internal` high and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_internal | input | 1 | Lookup is internal; replacement counter is not advanced |
| lk_va | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space identifier |
| sup_mode | input | 1 | Processor is in supervisor mode |
| single_virt | input | 1 | Single-virtual-space mode enable |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Index of the entry to write |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_asid | input | 8 | ASID of the written entry |
| wr_ppn | input | 22 | Physical page number (address bits 31:10) |
| wr_size | input | 2 | Page size code |
| wr_shared | input | 1 | Shared page, no ASID compare |
| wr_prot | input | 2 | Protection field |
| wr_dirty | input | 1 | Dirty bit |
| flush | input | 1 | Invalidate all entries |
| repl_bound | input | 6 | Replacement counter boundary |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_status | output | 2 | 00 miss, 01 hit, 10 multi-hit |
| rsp_pa | output | 32 | Translated physical address |
| rsp_prot | output | 2 | Protection field of the matching entry |
| rsp_dirty | output | 1 | Dirty bit of the matching entry |
| repl_count | output | 6 | Replacement counter |

## Verification
Each lookup result is due in the cycle after its request edge. The driver tags every expected item with that cycle number, and the monitor compares the tag against its own cycle count, so a late, early or missing result is reported. The replacement counter changes at the same edge that captures the request. It is therefore compared against the bench model in the cycle after each driven step. Lookups issued together with a write or a flush are predicted from the model before the write or flush is applied, which checks that the lookup uses the old table contents.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int VA_W   = 32;
  localparam int OFS_W  = 10;
  localparam int ASID_W = 8;
  localparam int VPN_W  = VA_W - OFS_W;

  typedef enum logic [1:0] {
    ST_MISS  = 2'b00,
    ST_HIT   = 2'b01,
    ST_MULTI = 2'b10
  } lk_status_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  ppn;
    logic [1:0]        size;
    logic              shared;
    logic [1:0]        prot;
    logic              dirty;
  } tlb_ent_t;

  // page-number bits that survive the page size (1K, 4K, 64K, 1M)
  function automatic logic [VPN_W-1:0] page_keep_mask(input logic [1:0] sz);
    int unsigned drop;
    case (sz)
      2'd0:    drop = 0;
      2'd1:    drop = 2;
      2'd2:    drop = 6;
      default: drop = 10;
    endcase
    return {VPN_W{1'b1}} << drop;
  endfunction
endpackage

// File: rtl/vpt_store.sv
module vpt_store
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  tlb_ent_t                   wr_ent,
  input  logic                       flush,
  output tlb_ent_t [ENTRIES-1:0]     ents
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ents <= '0;
    end else begin
      if (flush) begin
        for (int i = 0; i < ENTRIES; i++) ents[i].valid <= 1'b0;
      end
      if (wr_en) ents[wr_idx] <= wr_ent;   // later assignment wins over flush
    end
  end

  logic [ENTRIES-1:0] valid_vec;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) valid_vec[i] = ents[i].valid;
  end

  // R4: a flush with no write leaves no valid entry
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (flush && !wr_en) |=> (valid_vec == '0));
endmodule

// File: rtl/vpt_lane.sv
module vpt_lane
  import vpt_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic [VPN_W-1:0]  va_vpn,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              sup_mode,
  input  logic              single_virt,
  output logic              hit,
  output logic [VPN_W-1:0]  pa_hi,
  output logic [1:0]        prot,
  output logic              dirty
);
  logic [VPN_W-1:0] keep;
  logic             page_eq;
  logic             asid_ok;

  always_comb begin
    keep    = page_keep_mask(ent.size);
    page_eq = ((ent.vpn ^ va_vpn) & keep) == '0;
    asid_ok = ent.shared | (sup_mode & single_virt) | (ent.asid == cur_asid);
    hit     = ent.valid & page_eq & asid_ok;
    pa_hi   = hit ? ((ent.ppn & keep) | (va_vpn & ~keep)) : '0;
    prot    = hit ? ent.prot  : 2'b00;
    dirty   = hit & ent.dirty;
  end
endmodule

// File: rtl/vpt_resolve.sv
module vpt_resolve
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [ENTRIES-1:0]            hit_vec,
  input  logic [ENTRIES-1:0][VPN_W-1:0] pa_vec,
  input  logic [ENTRIES-1:0][1:0]       prot_vec,
  input  logic [ENTRIES-1:0]            dirty_vec,
  input  logic [OFS_W-1:0]              va_ofs,
  output lk_status_e                    status,
  output logic [VA_W-1:0]               pa,
  output logic [1:0]                    prot,
  output logic                          dirty
);
  logic [VPN_W-1:0] pa_or;
  logic [1:0]       prot_or;
  logic             any, multi;

  always_comb begin
    pa_or   = '0;
    prot_or = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      pa_or   = pa_or   | pa_vec[i];
      prot_or = prot_or | prot_vec[i];
    end
    any   = |hit_vec;
    multi = |(hit_vec & (hit_vec - 1'b1));
    if (!any)       status = ST_MISS;
    else if (multi) status = ST_MULTI;
    else            status = ST_HIT;
    pa    = (status == ST_HIT) ? {pa_or, va_ofs} : '0;
    prot  = (status == ST_HIT) ? prot_or : 2'b00;
    dirty = (status == ST_HIT) && (|dirty_vec);
  end

  // R7: a hit status means exactly one lane matched
  always_comb begin
    a_r7_single_lane: assert (status != ST_HIT || $countones(hit_vec) == 1);
  end
endmodule

// File: rtl/vpt_repl_ctr.sv
module vpt_repl_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] bound,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] nxt;
  assign nxt = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= (nxt == bound) ? '0 : nxt;
  end

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));
  a_r10_rollover: assert property (@(posedge clk) disable iff (rst)
    (step && (CNT_W'(count + 1'b1) == bound)) |=> (count == '0));
endmodule

// File: rtl/vp_tlb.sv
module vp_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic              lk_internal,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              sup_mode,
  input  logic              single_virt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_ppn,
  input  logic [1:0]        wr_size,
  input  logic              wr_shared,
  input  logic [1:0]        wr_prot,
  input  logic              wr_dirty,
  input  logic              flush,
  input  logic [IDX_W-1:0]  repl_bound,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_prot,
  output logic              rsp_dirty,
  output logic [IDX_W-1:0]  repl_count
);
  tlb_ent_t                      wr_ent;
  tlb_ent_t [ENTRIES-1:0]        ents;
  logic [ENTRIES-1:0]            hit_vec;
  logic [ENTRIES-1:0][VPN_W-1:0] pa_vec;
  logic [ENTRIES-1:0][1:0]       prot_vec;
  logic [ENTRIES-1:0]            dirty_vec;
  lk_status_e                    c_status;
  logic [VA_W-1:0]               c_pa;
  logic [1:0]                    c_prot;
  logic                          c_dirty;

  always_comb begin
    wr_ent = '{valid: wr_valid, vpn: wr_vpn, asid: wr_asid, ppn: wr_ppn,
               size: wr_size, shared: wr_shared, prot: wr_prot, dirty: wr_dirty};
  end

  vpt_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .flush(flush), .ents(ents)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
    vpt_lane u_lane (
      .ent(ents[g]), .va_vpn(lk_va[VA_W-1:OFS_W]), .cur_asid(cur_asid),
      .sup_mode(sup_mode), .single_virt(single_virt),
      .hit(hit_vec[g]), .pa_hi(pa_vec[g]), .prot(prot_vec[g]), .dirty(dirty_vec[g])
    );
  end

  vpt_resolve #(.ENTRIES(ENTRIES)) u_resolve (
    .hit_vec(hit_vec), .pa_vec(pa_vec), .prot_vec(prot_vec), .dirty_vec(dirty_vec),
    .va_ofs(lk_va[OFS_W-1:0]), .status(c_status), .pa(c_pa),
    .prot(c_prot), .dirty(c_dirty)
  );

  vpt_repl_ctr #(.CNT_W(IDX_W)) u_repl (
    .clk(clk), .rst(rst), .step(lk_req && !lk_internal),
    .bound(repl_bound), .count(repl_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_pa     <= '0;
      rsp_prot   <= '0;
      rsp_dirty  <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_status <= c_status;
        rsp_pa     <= c_pa;
        rsp_prot   <= c_prot;
        rsp_dirty  <= c_dirty;
      end
    end
  end

  a_r2_resp_due: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);
  a_r7_nohit_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_HIT) |-> (rsp_pa == '0 && rsp_prot == '0 && !rsp_dirty));
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (rsp_status != ST_HIT || rsp_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0])));
endmodule

// File: tb/vp_tlb_bench.sv
`timescale 1ns/1ps
module vp_tlb_bench;
  import vpt_pkg::*;
  localparam int N = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, lk_req, lk_internal, sup_mode, single_virt, wr_en, wr_valid;
  logic wr_shared, wr_dirty, flush, rsp_valid, rsp_dirty;
  logic [31:0] lk_va, rsp_pa;
  logic [7:0] cur_asid, wr_asid;
  logic [5:0] wr_idx, repl_bound, repl_count;
  logic [21:0] wr_vpn, wr_ppn;
  logic [1:0] wr_size, wr_prot, rsp_status, rsp_prot;

  vp_tlb u_vp_tlb (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_internal(lk_internal), .lk_va(lk_va),
    .cur_asid(cur_asid), .sup_mode(sup_mode), .single_virt(single_virt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_size(wr_size), .wr_shared(wr_shared),
    .wr_prot(wr_prot), .wr_dirty(wr_dirty), .flush(flush), .repl_bound(repl_bound),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
    .rsp_prot(rsp_prot), .rsp_dirty(rsp_dirty), .repl_count(repl_count)
  );

  typedef struct {
    logic [1:0]  st;
    logic [31:0] pa;
    logic [1:0]  prot;
    logic        dirty;
    int          due;
    string       tag;
  } exp_t;

  exp_t     q[$];
  tlb_ent_t mdl[N];
  logic [5:0] mcnt;
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic tlb_ent_t mk(input logic v, input logic [31:0] vbase, input logic [7:0] asid,
                                  input logic [31:0] pbase, input logic [1:0] sz, input logic sh,
                                  input logic [1:0] pr, input logic d);
    tlb_ent_t e;
    e.valid = v; e.vpn = vbase[31:10]; e.asid = asid; e.ppn = pbase[31:10];
    e.size = sz; e.shared = sh; e.prot = pr; e.dirty = d;
    return e;
  endfunction

  // expected result from the requirement text (R5..R9)
  function automatic exp_t predict(input logic [31:0] va);
    exp_t r;
    int n = 0;
    r.pa = '0; r.prot = '0; r.dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      int ob;
      logic [31:0] vb, pb;
      ob = (mdl[i].size == 2'd0) ? 10 : (mdl[i].size == 2'd1) ? 12 : (mdl[i].size == 2'd2) ? 16 : 20;
      vb = {mdl[i].vpn, 10'b0};
      pb = {mdl[i].ppn, 10'b0};
      if (mdl[i].valid && ((vb >> ob) == (va >> ob)) &&
          (mdl[i].shared || (sup_mode && single_virt) || mdl[i].asid == cur_asid)) begin
        n++;
        r.pa = ((pb >> ob) << ob) | (va & ((32'd1 << ob) - 1));
        r.prot = mdl[i].prot;
        r.dirty = mdl[i].dirty;
      end
    end
    if (n == 1) r.st = 2'b01;
    else begin
      r.st = (n == 0) ? 2'b00 : 2'b10;
      r.pa = '0; r.prot = '0; r.dirty = 1'b0;
    end
    return r;
  endfunction

  task automatic step(input logic req, input logic [31:0] va, input logic intl, input logic wr,
                      input int idx, input tlb_ent_t ent, input logic fl, input string tag);
    lk_req = req; lk_va = va; lk_internal = intl; flush = fl; wr_en = wr;
    wr_idx = 6'(idx); wr_valid = ent.valid; wr_vpn = ent.vpn; wr_asid = ent.asid;
    wr_ppn = ent.ppn; wr_size = ent.size; wr_shared = ent.shared; wr_prot = ent.prot;
    wr_dirty = ent.dirty;
    if (req) begin
      exp_t e;
      e = predict(va);
      e.due = cyc + 1;
      e.tag = tag;
      q.push_back(e);
    end
    if (fl) for (int i = 0; i < N; i++) mdl[i].valid = 1'b0;
    if (wr) mdl[idx] = ent;
    if (req && !intl) begin
      mcnt = mcnt + 6'd1;
      if (mcnt == repl_bound) mcnt = '0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(repl_count == mcnt, {"R10 counter ", tag}, 64'(repl_count), 64'(mcnt));
  endtask

  task automatic look(input logic [31:0] va, input string tag);
    step(1'b1, va, 1'b0, 1'b0, 0, '0, 1'b0, tag);
  endtask
  task automatic put(input int idx, input tlb_ent_t e);
    step(1'b0, 32'h0, 1'b0, 1'b1, idx, e, 1'b0, "R3 write");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (rsp_valid) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected rsp_valid", 64'(1), 64'(0));
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.due == cyc, {"R2 due cycle ", e.tag}, 64'(cyc), 64'(e.due));
          chk(rsp_status == e.st, {"R7 status ", e.tag}, 64'(rsp_status), 64'(e.st));
          chk(rsp_pa == e.pa, {"R8 pa ", e.tag}, 64'(rsp_pa), 64'(e.pa));
          chk(rsp_prot == e.prot && rsp_dirty == e.dirty, {"R9 prot/dirty ", e.tag},
              64'({rsp_prot, rsp_dirty}), 64'({e.prot, e.dirty}));
        end
      end else if (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(1'b0, {"R2 missing response ", e.tag}, 64'(0), 64'(1));
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; lk_req = 0; lk_internal = 0; lk_va = 0; cur_asid = 8'd5; sup_mode = 0;
    single_virt = 0; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_vpn = 0; wr_asid = 0;
    wr_ppn = 0; wr_size = 0; wr_shared = 0; wr_prot = 0; wr_dirty = 0; flush = 0;
    repl_bound = 0; mcnt = 0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'(0));
    chk(repl_count == 6'd0, "R1 counter after reset", 64'(repl_count), 64'(0));
    rst = 0;

    look(32'h0000_0000, "R1 empty table miss");
    put(0, mk(1, 32'h1234_5400, 8'd5, 32'h0ABC_D000, 2'd0, 0, 2'd3, 1));
    look(32'h1234_57FC, "R5 1K page hit");
    look(32'h1234_5800, "R5 1K page boundary miss");
    cur_asid = 8'd6;
    look(32'h1234_5400, "R6 asid mismatch miss");
    sup_mode = 1;
    look(32'h1234_5400, "R6 supervisor without single-virtual miss");
    single_virt = 1;
    look(32'h1234_5404, "R6 supervisor single-virtual skips asid");
    sup_mode = 0;
    look(32'h1234_5404, "R6 single-virtual in user mode miss");
    single_virt = 0; cur_asid = 8'd5;

    put(1, mk(1, 32'h2000_3000, 8'd9, 32'h4440_1000, 2'd1, 1, 2'd1, 0));
    look(32'h2000_3FFE, "R5 R6 4K shared page hit");
    look(32'h2000_4000, "R5 4K page boundary miss");
    put(2, mk(1, 32'h3005_0000, 8'd5, 32'h7777_0000, 2'd2, 0, 2'd2, 1));
    look(32'h3005_ABCD, "R5 R8 64K page hit");
    look(32'h3006_0000, "R5 64K page boundary miss");
    put(3, mk(1, 32'h40F5_6C00, 8'd5, 32'h0123_4400, 2'd3, 0, 2'd1, 1));
    look(32'h40F8_1234, "R5 R8 1M page ignores low stored bits");
    put(4, mk(1, 32'h40F8_1000, 8'd5, 32'h0555_0000, 2'd0, 0, 2'd0, 0));
    look(32'h40F8_1234, "R7 overlapping pages multi-hit");
    look(32'h40F0_0000, "R7 single hit beside overlap");
    put(5, mk(0, 32'h5000_0000, 8'd5, 32'h0100_0000, 2'd0, 0, 2'd3, 1));
    look(32'h5000_0000, "R4 invalid entry miss");

    step(1, 32'h1234_5404, 0, 1, 0, mk(1, 32'h1234_5400, 8'd5, 32'h0DDD_0000, 2'd0, 0, 2'd2, 0),
         0, "R2 lookup sees old entry during write");
    look(32'h1234_5404, "R3 rewritten entry applies");
    step(1, 32'h3005_0010, 0, 0, 0, '0, 1, "R2 lookup sees entries during flush");
    look(32'h3005_0010, "R4 flushed entry miss");
    look(32'h40F0_0000, "R4 flushed 1M entry miss");
    step(0, 32'h0, 0, 1, 6, mk(1, 32'h6000_0000, 8'd5, 32'h1000_0000, 2'd0, 0, 2'd3, 0),
         1, "R4 write with flush");
    look(32'h6000_0004, "R4 write beats flush");

    repl_bound = 6'd5;
    for (int i = 0; i < 8; i++) look(32'h6000_0000 + 32'(i * 4), "R10 bound 5");
    for (int i = 0; i < 3; i++) step(1, 32'h6000_0008, 1, 0, 0, '0, 0, "R10 internal lookup");
    repl_bound = 6'd0;
    for (int i = 0; i < 70; i++) look(32'h0000_1000, "R10 wrap through 63");
    step(0, 32'h0, 0, 0, 0, '0, 0, "R10 idle");
    step(0, 32'h0, 0, 0, 0, '0, 0, "R10 idle");
    chk(q.size() == 0, "R2 all responses seen", 64'(q.size()), 64'(0));

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule